// File: doc/BRIEF.md
# Set/Clear Aliased Control Register Bank

This block is a bank of control registers on an APB target port. Each register can be changed one bit at a time, with no read-modify-write sequence. It has three word addresses. One is a write-one-to-set port, one is a write-one-to-clear port, and one returns the stored value when read. A bit written as zero at either of the two write ports keeps its old value. Two agents can therefore each own different bits of the same register without racing each other.

The bank responds only inside one 16 KB address window. The window starts at a base address that is a parameter and is the lowest address of the window. Register `i` takes word offsets `3*i` (set), `3*i+1` (clear) and `3*i+2` (value) from that base. Any access outside these offsets completes with an error response. The stored values are driven out in parallel from flip-flops, so the peripheral logic behind the bank can use them.

Top module: `sca_bank`

## Requirements
- R1: While reset is asserted, and right after it is released, every register reads zero, `regs_o` is all zeros, and `prdata` and `pslverr` are 0.
- R2: A completed write to a set address forces to 1 each register bit whose `pwdata` bit is 1. Bits written as 0 keep their value.
- R3: A completed write to a clear address forces to 0 each register bit whose `pwdata` bit is 1. Bits written as 0 keep their value.
- R4: A read of a value address returns the current stored contents of that register on `prdata` during the access phase.
- R5: A write to a value address changes no register.
- R6: A read of a set or clear address returns zero. During a write, `prdata` is zero.
- R7: Register `i` (bit field `regs_o[32*i +: 32]`) is at byte offset `12*i` for set, `12*i+4` for clear and `12*i+8` for value, counted from the base. `paddr[1:0]` is ignored.
- R8: An access is decoded only when `paddr[31:14]` equals the base's `paddr[31:14]` and the word offset is below `3*NUM_REGS`. Any other access has `pslverr` = 1 in its access phase, `prdata` = 0, and changes no register.
- R9: `pready` is 1 at all times, so every transfer takes exactly one setup and one access cycle.
- R10: A register changes only on the clock edge that completes the APB write access (`psel` and `penable` high). The setup-phase edge changes nothing.
- R11: `regs_o` always equals the stored register contents. It is driven directly by the register flip-flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable, high in the access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte address |
| pwdata | input | DATA_W | Write data / bit mask |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Error response for undecoded addresses |
| regs_o | output | NUM_REGS*DATA_W | Stored register values, register i at bits [DATA_W*i +: DATA_W] |

## Verification
The bench builds the bank with `NUM_REGS` = 5 and a base of `32'h4001_C000`, which is not the default. An odd register count puts the last valid word at offset 14 and the first invalid one at offset 15, inside the same power-of-two word range. This tests that the offset limit is decoded exactly and not by rounding up to whole address bits. Because the base is non-zero, addresses in the neighbouring window are also reached, which tests the window compare on the upper address bits.

// File: rtl/sca_pkg.sv
package sca_pkg;

  // Which of the three aliases of a register an access targets.
  typedef enum logic [1:0] {
    ALIAS_SET = 2'd0,
    ALIAS_CLR = 2'd1,
    ALIAS_VAL = 2'd2
  } alias_e;

endpackage

// File: rtl/sca_decode.sv
module sca_decode
  import sca_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned WIN_BITS  = 14,
  parameter int unsigned NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic [ADDR_W-1:0]   paddr,
  output logic                hit,
  output logic [NUM_REGS-1:0] sel,
  output alias_e              kind
);

  localparam int unsigned WORD_W = WIN_BITS - 2;

  logic [WORD_W-1:0]   word;
  logic                in_win;
  logic [NUM_REGS-1:0] hit_set;
  logic [NUM_REGS-1:0] hit_clr;
  logic [NUM_REGS-1:0] hit_val;
  logic                unused_lowbits;

  assign word           = paddr[WIN_BITS-1:2];
  assign in_win         = (paddr[ADDR_W-1:WIN_BITS] == BASE_ADDR[ADDR_W-1:WIN_BITS]);
  assign unused_lowbits = ^paddr[1:0];

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_slot
      localparam logic [WORD_W-1:0] W_SET = WORD_W'(3 * g);
      localparam logic [WORD_W-1:0] W_CLR = WORD_W'(3 * g + 1);
      localparam logic [WORD_W-1:0] W_VAL = WORD_W'(3 * g + 2);
      assign hit_set[g] = in_win && (word == W_SET);
      assign hit_clr[g] = in_win && (word == W_CLR);
      assign hit_val[g] = in_win && (word == W_VAL);
    end
  endgenerate

  assign sel = hit_set | hit_clr | hit_val;
  assign hit = |sel;

  always_comb begin
    if (|hit_clr)      kind = ALIAS_CLR;
    else if (|hit_val) kind = ALIAS_VAL;
    else               kind = ALIAS_SET;
  end

endmodule

// File: rtl/sca_cell.sv
module sca_cell #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)         q <= '0;
    else if (set_en) q <= q | mask;
    else if (clr_en) q <= q & ~mask;
  end

endmodule

// File: rtl/sca_rdmux.sv
module sca_rdmux
  import sca_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       setup,
  input  logic                       pwrite,
  input  logic                       hit,
  input  logic [NUM_REGS-1:0]        sel,
  input  alias_e                     kind,
  input  logic [NUM_REGS*DATA_W-1:0] regs,
  output logic [DATA_W-1:0]          prdata,
  output logic                       pslverr
);

  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (sel[i]) rd_val = rd_val | regs[i*DATA_W +: DATA_W];
    end
  end

  // Captured on the setup edge so the response is a flop output in the access phase.
  always_ff @(posedge clk) begin
    if (rst) begin
      prdata  <= '0;
      pslverr <= 1'b0;
    end else if (setup) begin
      pslverr <= !hit;
      prdata  <= (hit && !pwrite && kind == ALIAS_VAL) ? rd_val : '0;
    end else begin
      pslverr <= 1'b0;
      prdata  <= '0;
    end
  end

endmodule

// File: rtl/sca_bank.sv
module sca_bank
  import sca_pkg::*;
#(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned WIN_BITS  = 14,
  parameter int unsigned NUM_REGS  = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'h4000_0000
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       psel,
  input  logic                       penable,
  input  logic                       pwrite,
  input  logic [ADDR_W-1:0]          paddr,
  input  logic [DATA_W-1:0]          pwdata,
  output logic [DATA_W-1:0]          prdata,
  output logic                       pready,
  output logic                       pslverr,
  output logic [NUM_REGS*DATA_W-1:0] regs_o
);

  localparam int unsigned WORDS = 3 * NUM_REGS;

  initial begin
    if (WORDS > (1 << (WIN_BITS - 2)))
      $error("sca_bank: register aliases do not fit in the window");
  end

  logic                setup;
  logic                wr_done;
  logic                hit;
  logic [NUM_REGS-1:0] sel;
  alias_e              kind;

  assign setup   = psel && !penable;
  assign wr_done = psel && penable && pwrite && hit;
  assign pready  = 1'b1;

  sca_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS),
    .NUM_REGS (NUM_REGS),
    .BASE_ADDR(BASE_ADDR)
  ) u_decode (
    .paddr(paddr),
    .hit  (hit),
    .sel  (sel),
    .kind (kind)
  );

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_reg
      logic set_en;
      logic clr_en;
      assign set_en = wr_done && sel[g] && (kind == ALIAS_SET);
      assign clr_en = wr_done && sel[g] && (kind == ALIAS_CLR);
      sca_cell #(.DATA_W(DATA_W)) u_cell (
        .clk   (clk),
        .rst   (rst),
        .set_en(set_en),
        .clr_en(clr_en),
        .mask  (pwdata),
        .q     (regs_o[g*DATA_W +: DATA_W])
      );
    end
  endgenerate

  sca_rdmux #(
    .DATA_W  (DATA_W),
    .NUM_REGS(NUM_REGS)
  ) u_rdmux (
    .clk    (clk),
    .rst    (rst),
    .setup  (setup),
    .pwrite (pwrite),
    .hit    (hit),
    .sel    (sel),
    .kind   (kind),
    .regs   (regs_o),
    .prdata (prdata),
    .pslverr(pslverr)
  );

endmodule

// File: rtl/sca_bank_chk.sv
module sca_bank_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       psel,
  input logic                       penable,
  input logic                       pwrite,
  input logic [ADDR_W-1:0]          paddr,
  input logic [DATA_W-1:0]          pwdata,
  input logic [DATA_W-1:0]          prdata,
  input logic                       pready,
  input logic                       pslverr,
  input logic [NUM_REGS*DATA_W-1:0] regs_o
);

  logic unused_chk;
  assign unused_chk = ^paddr ^ pready;

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(psel && penable && pwrite) |=> $stable(regs_o));

  // R8
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pslverr) |=> $stable(regs_o));

  // R8
  err_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pslverr) |-> (prdata == '0));

  // R8
  err_phase_chk: assert property (@(posedge clk) disable iff (rst)
    pslverr |-> (psel && penable));

  // R6
  wr_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && pwrite) |-> (prdata == '0));

  // R2, R3
  single_dir_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (((regs_o & ~$past(regs_o)) == '0) || ((~regs_o & $past(regs_o)) == '0)));

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_mask
      // R2, R3
      zero_bits_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (psel && penable && pwrite) |=>
          (((regs_o[g*DATA_W +: DATA_W] ^ $past(regs_o[g*DATA_W +: DATA_W])) & ~$past(pwdata)) == '0));
    end
  endgenerate

endmodule

bind sca_bank sca_bank_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .NUM_REGS(NUM_REGS)
) u_chk (
  .clk    (clk),
  .rst    (rst),
  .psel   (psel),
  .penable(penable),
  .pwrite (pwrite),
  .paddr  (paddr),
  .pwdata (pwdata),
  .prdata (prdata),
  .pready (pready),
  .pslverr(pslverr),
  .regs_o (regs_o)
);

// File: tb/sca_bank_bench.sv
module sca_bank_bench;

  localparam int unsigned NR   = 5;
  localparam int unsigned DW   = 32;
  localparam logic [31:0] BASE = 32'h4001_C000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          psel = 1'b0;
  logic          penable = 1'b0;
  logic          pwrite = 1'b0;
  logic [31:0]   paddr = '0;
  logic [31:0]   pwdata = '0;
  logic [31:0]   prdata;
  logic          pready;
  logic          pslverr;
  logic [NR*DW-1:0] regs_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] model [NR];

  always #4 clk = ~clk;

  sca_bank #(
    .DATA_W(DW), .NUM_REGS(NR), .BASE_ADDR(BASE)
  ) u_sca_bank (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .regs_o(regs_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic valid_addr(logic [31:0] a);
    return (a[31:14] == BASE[31:14]) && (a[13:2] < 12'(3 * NR));
  endfunction

  function automatic int reg_of(logic [31:0] a);
    return int'(a[13:2]) / 3;
  endfunction

  function automatic int alias_of(logic [31:0] a);
    return int'(a[13:2]) % 3;
  endfunction

  function automatic logic [31:0] exp_read(logic [31:0] a);
    if (valid_addr(a) && alias_of(a) == 2) return model[reg_of(a)];
    return '0;
  endfunction

  task automatic chk_all_regs(string req);
    for (int i = 0; i < NR; i++) chk(req, regs_o[i*DW +: DW], model[i]);
  endtask

  task automatic apb_write(logic [31:0] a, logic [31:0] d, string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    chk_all_regs("R10 no update at setup edge");
    chk("R8 pslverr on write", 32'(pslverr), 32'(!valid_addr(a)));
    chk("R9 pready", 32'(pready), 32'd1);
    @(posedge clk);
    if (valid_addr(a)) begin
      if (alias_of(a) == 0) model[reg_of(a)] = model[reg_of(a)] | d;
      else if (alias_of(a) == 1) model[reg_of(a)] = model[reg_of(a)] & ~d;
    end
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    chk_all_regs(req);
  endtask

  task automatic apb_read(logic [31:0] a, string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    chk(req, prdata, exp_read(a));
    chk("R8 pslverr on read", 32'(pslverr), 32'(!valid_addr(a)));
    @(posedge clk);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (2) @(negedge clk);
    chk_all_regs("R1 regs during reset");
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk_all_regs("R1 regs after reset");
    chk("R1 prdata", prdata, '0);
    chk("R1 pslverr", 32'(pslverr), '0);
    apb_read(BASE + 32'd8, "R1 value read after reset");

    // Directed corner cases
    apb_write(BASE + 32'd0, 32'hA5A5_00FF, "R2 set reg0");
    apb_read (BASE + 32'd8, "R4 value reg0");
    apb_write(BASE + 32'd4, 32'h0000_00F0, "R3 clear reg0");
    apb_read (BASE + 32'd8, "R4 value reg0 after clear");
    apb_write(BASE + 32'd12, 32'hFFFF_FFFF, "R2 set all reg1");
    apb_write(BASE + 32'd12, 32'h0000_0000, "R2 zero set no effect");
    apb_write(BASE + 32'd16, 32'h0000_0000, "R3 zero clear no effect");
    apb_write(BASE + 32'd16, 32'h8000_0001, "R3 clear edge bits reg1");
    apb_write(BASE + 32'd32, 32'hDEAD_BEEF, "R5 write to value ignored");
    apb_read (BASE + 32'd32, "R5 value reg2 still zero");
    apb_read (BASE + 32'd0, "R6 read set alias zero");
    apb_read (BASE + 32'd4, "R6 read clear alias zero");
    apb_write(BASE + 32'd60, 32'hFFFF_FFFF, "R8 write word 15 rejected");
    apb_read (BASE + 32'd60, "R8 read word 15 zero");
    apb_write(BASE + 32'h0000_4000, 32'hFFFF_FFFF, "R8 write next window rejected");
    apb_write(BASE - 32'h0000_4000, 32'hFFFF_FFFF, "R8 write prior window rejected");
    apb_write(BASE + 32'd51, 32'h1234_5678, "R7 low addr bits ignored reg4 set");
    apb_read (BASE + 32'd56, "R7 last value alias reg4");
    apb_read (BASE + 32'd57, "R7 value alias low bits ignored");

    // Constrained random traffic
    void'($urandom(32'd2718));
    for (int n = 0; n < 500; n++) begin
      logic [31:0] a;
      logic [31:0] d;
      if ($urandom % 8 == 0)
        a = (BASE ^ (32'h0000_4000 << ($urandom % 18))) | ($urandom % 64);
      else
        a = BASE + (($urandom % 16) * 4) + ($urandom % 4);
      d = $urandom;
      if ($urandom % 2 == 0) apb_write(a, d, "R11 regs_o after random write");
      else apb_read(a, "R4 R6 random read");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule